// File: doc/BRIEF.md
# Block Address Translation Matcher

This block maps a 32-bit effective address onto a real address through a small set of fixed-size translation windows. Two banks of windows are kept, one used for instruction fetches and one for data accesses. Each window carries its own enable for supervisor mode and for user mode, a tag with a mask that selects which address bits are compared, a real block number, and a two-bit protection code. The bank is chosen by the access type.

A lookup is purely combinational. The address, the access type, the privilege level and a write flag go in. In the same cycle the block returns a hit, the translated address and the read, write and execute rights. A window whose tag matches but whose protection refuses the access does not end the search. The search moves on to the next window, and the lowest-numbered window that both matches and permits the access wins. When windows matched but every one of them refused, a fault flag is raised instead of a hit. Windows are loaded one at a time through a write port, and a load is visible to lookups from the next cycle on.

Top module: `bat_xlate`

## Requirements
- R1: After reset every window in both banks is disabled, so every lookup misses with the fault flag low.
- R2: A lookup with `acc_data`=1 searches only the data bank, and a lookup with `acc_data`=0 searches only the instruction bank. A load with `cfg_data_bank`=1 writes the data bank.
- R3: In user mode (`acc_user`=1) a window takes part only if its user enable is set. In supervisor mode it takes part only if its supervisor enable is set.
- R4: A window's tag matches when (`acc_ea` AND mask) equals its tag.
- R5: On a hit, `xl_raddr` equals the winning window's real block number ORed with the address bits that are clear in its mask.
- R6: Protection codes: 0 grants nothing, 1 grants read only, and 2 or 3 grant read and write. On a hit, `xl_rd`=1 and `xl_wr` equals bit 1 of the code.
- R7: Every hit reports `xl_ex`=1.
- R8: A tag-matching window with code 0 is skipped, and the search continues with higher-numbered windows.
- R9: A write to a tag-matching window with code 1 is skipped. A read through the same window hits.
- R10: Of several qualifying windows, the lowest index wins.
- R11: On a miss, `xl_hit`, `xl_rd`, `xl_wr` and `xl_ex` are 0 and `xl_raddr` is 0.
- R12: `xl_fault` is 1 exactly when at least one enabled window's tag matches and no window qualifies. It is never 1 together with `xl_hit`.
- R13: A load with `cfg_we`=1 replaces only the selected window of the selected bank, and the new contents govern lookups from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load one window this cycle |
| cfg_data_bank | input | 1 | Load target: 1 data bank, 0 instruction bank |
| cfg_idx | input | IW | Window index to load |
| cfg_sup_en | input | 1 | Supervisor enable of the loaded window |
| cfg_usr_en | input | 1 | User enable of the loaded window |
| cfg_tag | input | 32 | Tag of the loaded window |
| cfg_mask | input | 32 | Compare mask of the loaded window |
| cfg_rbn | input | 32 | Real block number of the loaded window |
| cfg_prot | input | 2 | Protection code of the loaded window |
| acc_ea | input | 32 | Effective address to translate |
| acc_data | input | 1 | 1 data access, 0 instruction fetch |
| acc_user | input | 1 | 1 user mode, 0 supervisor mode |
| acc_write | input | 1 | Access is a write |
| xl_hit | output | 1 | A window qualified |
| xl_fault | output | 1 | Windows matched but all refused |
| xl_raddr | output | 32 | Translated address |
| xl_rd | output | 1 | Read permitted |
| xl_wr | output | 1 | Write permitted |
| xl_ex | output | 1 | Execute permitted |

## Verification
The hardest case to reach is a search that has to pass over refused windows: a low-numbered window whose tag matches but whose code forbids the access, sitting in front of a higher one that permits it. It must also be told apart from the case where every matching window refuses, which has to raise the fault. Random tags almost never overlap, so the stimulus loads overlapping windows on purpose, with nested masks over the same region and different codes. It then runs read and write accesses in both modes through them. A random phase draws masks from a few nested widths and aims most addresses inside a window already loaded, which keeps overlaps common.

// File: rtl/bat_pkg.sv
package bat_pkg;
    parameter int unsigned BAT_AW = 32;

    typedef logic [BAT_AW-1:0] bat_addr_t;

    typedef enum logic [1:0] {
        PROT_NONE = 2'd0,
        PROT_RO   = 2'd1,
        PROT_RW   = 2'd2,
        PROT_RW_B = 2'd3
    } bat_prot_e;

    typedef struct packed {
        logic      sup_en;
        logic      usr_en;
        bat_addr_t tag;
        bat_addr_t mask;
        bat_addr_t rbn;
        bat_prot_e prot;
    } bat_entry_t;

    typedef struct packed {
        logic      hit;
        logic      fault;
        bat_addr_t raddr;
        logic      rd;
        logic      wr;
        logic      ex;
    } bat_result_t;
endpackage

// File: rtl/bat_store.sv
module bat_store import bat_pkg::*; #(
    parameter int unsigned ENTRIES = 8,
    localparam int unsigned IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      wr_side,
    input  logic [IW-1:0]             wr_idx,
    input  bat_entry_t                wr_entry,
    input  logic                      rd_side,
    output bat_entry_t [ENTRIES-1:0]  bank_o
);
    bat_entry_t [1:0][ENTRIES-1:0] tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en && (32'(wr_idx) < ENTRIES)) begin
            tbl_d[wr_side][wr_idx] = wr_entry;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign bank_o = tbl_q[rd_side];

    a_r13_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (32'(wr_idx) < ENTRIES)) |=>
            (tbl_q[$past(wr_side)][$past(wr_idx)] == $past(wr_entry)));
endmodule

// File: rtl/bat_match.sv
module bat_match import bat_pkg::*; #(
    parameter int unsigned ENTRIES = 8
) (
    input  bat_entry_t [ENTRIES-1:0] bank_i,
    input  bat_addr_t                ea,
    input  logic                     user,
    input  logic                     write,
    output logic [ENTRIES-1:0]       tag_hit,
    output logic [ENTRIES-1:0]       qual
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        logic enabled;
        logic refused;
        assign enabled = user ? bank_i[i].usr_en : bank_i[i].sup_en;
        assign tag_hit[i] = enabled && ((ea & bank_i[i].mask) == bank_i[i].tag);
        assign refused = (bank_i[i].prot == PROT_NONE) ||
                         (write && (bank_i[i].prot == PROT_RO));
        assign qual[i] = tag_hit[i] && !refused;
    end
endmodule

// File: rtl/bat_pick.sv
module bat_pick import bat_pkg::*; #(
    parameter int unsigned ENTRIES = 8
) (
    input  bat_entry_t [ENTRIES-1:0] bank_i,
    input  bat_addr_t                ea,
    input  logic [ENTRIES-1:0]       tag_hit,
    input  logic [ENTRIES-1:0]       qual,
    output bat_result_t              res
);
    logic found;

    always_comb begin
        res   = '0;
        found = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!found && qual[i]) begin
                found     = 1'b1;
                res.hit   = 1'b1;
                res.raddr = bank_i[i].rbn | (ea & ~bank_i[i].mask);
                res.rd    = 1'b1;
                res.wr    = bank_i[i].prot[1];
                res.ex    = 1'b1;
            end
        end
        res.fault = (|tag_hit) && !found;
    end
endmodule

// File: rtl/bat_xlate.sv
module bat_xlate import bat_pkg::*; #(
    parameter int unsigned ENTRIES = 8,
    localparam int unsigned IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_data_bank,
    input  logic [IW-1:0]     cfg_idx,
    input  logic              cfg_sup_en,
    input  logic              cfg_usr_en,
    input  logic [BAT_AW-1:0] cfg_tag,
    input  logic [BAT_AW-1:0] cfg_mask,
    input  logic [BAT_AW-1:0] cfg_rbn,
    input  logic [1:0]        cfg_prot,
    input  logic [BAT_AW-1:0] acc_ea,
    input  logic              acc_data,
    input  logic              acc_user,
    input  logic              acc_write,
    output logic              xl_hit,
    output logic              xl_fault,
    output logic [BAT_AW-1:0] xl_raddr,
    output logic              xl_rd,
    output logic              xl_wr,
    output logic              xl_ex
);
    bat_entry_t                new_ent;
    bat_entry_t [ENTRIES-1:0]  bank;
    logic [ENTRIES-1:0]        tag_hit;
    logic [ENTRIES-1:0]        qual;
    bat_result_t               res;

    always_comb begin
        new_ent.sup_en = cfg_sup_en;
        new_ent.usr_en = cfg_usr_en;
        new_ent.tag    = cfg_tag;
        new_ent.mask   = cfg_mask;
        new_ent.rbn    = cfg_rbn;
        new_ent.prot   = bat_prot_e'(cfg_prot);
    end

    bat_store #(.ENTRIES(ENTRIES)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_side  (cfg_data_bank),
        .wr_idx   (cfg_idx),
        .wr_entry (new_ent),
        .rd_side  (acc_data),
        .bank_o   (bank)
    );

    bat_match #(.ENTRIES(ENTRIES)) u_match (
        .bank_i  (bank),
        .ea      (acc_ea),
        .user    (acc_user),
        .write   (acc_write),
        .tag_hit (tag_hit),
        .qual    (qual)
    );

    bat_pick #(.ENTRIES(ENTRIES)) u_pick (
        .bank_i  (bank),
        .ea      (acc_ea),
        .tag_hit (tag_hit),
        .qual    (qual),
        .res     (res)
    );

    assign xl_hit   = res.hit;
    assign xl_fault = res.fault;
    assign xl_raddr = res.raddr;
    assign xl_rd    = res.rd;
    assign xl_wr    = res.wr;
    assign xl_ex    = res.ex;

    a_r12_fault_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(xl_hit && xl_fault));

    a_r7_exec_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        xl_hit |-> (xl_ex && xl_rd));

    a_r9_write_needs_right: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_hit && acc_write) |-> xl_wr);

    a_r11_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !xl_hit |-> (xl_raddr == '0 && !xl_rd && !xl_wr && !xl_ex));

    a_r12_fault_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        xl_fault |-> (tag_hit != '0));
endmodule

// File: tb/bat_xlate_tb_top.sv
module bat_xlate_tb_top;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_data_bank = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic        cfg_sup_en = 1'b0, cfg_usr_en = 1'b0;
    logic [31:0] cfg_tag = '0, cfg_mask = '0, cfg_rbn = '0;
    logic [1:0]  cfg_prot = '0;
    logic [31:0] acc_ea = '0;
    logic        acc_data = 1'b0, acc_user = 1'b0, acc_write = 1'b0;
    logic        xl_hit, xl_fault, xl_rd, xl_wr, xl_ex;
    logic [31:0] xl_raddr;

    always #5 clk = ~clk;

    bat_xlate #(.ENTRIES(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data_bank(cfg_data_bank),
        .cfg_idx(cfg_idx), .cfg_sup_en(cfg_sup_en), .cfg_usr_en(cfg_usr_en),
        .cfg_tag(cfg_tag), .cfg_mask(cfg_mask), .cfg_rbn(cfg_rbn), .cfg_prot(cfg_prot),
        .acc_ea(acc_ea), .acc_data(acc_data), .acc_user(acc_user), .acc_write(acc_write),
        .xl_hit(xl_hit), .xl_fault(xl_fault), .xl_raddr(xl_raddr),
        .xl_rd(xl_rd), .xl_wr(xl_wr), .xl_ex(xl_ex)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    string lbl    = "R1";

    logic        m_sv [2][N];
    logic        m_uv [2][N];
    logic [31:0] m_tag[2][N];
    logic [31:0] m_msk[2][N];
    logic [31:0] m_rbn[2][N];
    logic [1:0]  m_pr [2][N];

    task automatic check_now();
        int  side = acc_data ? 1 : 0;
        bit  any_match = 0;
        bit  got = 0;
        logic [36:0] exp_v = '0;
        logic [36:0] act_v;
        for (int i = 0; i < N; i++) begin
            bit en = acc_user ? m_uv[side][i] : m_sv[side][i];
            if (en && ((acc_ea & m_msk[side][i]) == m_tag[side][i])) begin
                any_match = 1;
                if (!got && m_pr[side][i] != 2'd0 && !(acc_write && m_pr[side][i] == 2'd1)) begin
                    got = 1;
                    exp_v = {1'b1, 1'b0, m_rbn[side][i] | (acc_ea & ~m_msk[side][i]),
                             1'b1, m_pr[side][i] >= 2'd2, 1'b1};
                end
            end
        end
        if (!got) exp_v[35] = any_match;
        act_v = {xl_hit, xl_fault, xl_raddr, xl_rd, xl_wr, xl_ex};
        checks++;
        if (act_v !== exp_v) begin
            fails++;
            $display("FAIL %s: ea=%h {hit,fault,raddr,rd,wr,ex} actual=%h expected=%h",
                     lbl, acc_ea, act_v, exp_v);
        end
    endtask

    task automatic step(input logic [31:0] ea, input bit d, input bit u, input bit w);
        @(negedge clk);
        acc_ea = ea; acc_data = d; acc_user = u; acc_write = w;
        #1 check_now();
    endtask

    task automatic load(input bit side, input int idx, input bit sv, input bit uv,
                        input logic [31:0] tag, input logic [31:0] msk,
                        input logic [31:0] rbn, input logic [1:0] pr);
        @(negedge clk);
        cfg_we = 1'b1; cfg_data_bank = side; cfg_idx = idx[2:0];
        cfg_sup_en = sv; cfg_usr_en = uv; cfg_tag = tag; cfg_mask = msk;
        cfg_rbn = rbn; cfg_prot = pr;
        #1 check_now();
        @(posedge clk);
        m_sv[side][idx] = sv; m_uv[side][idx] = uv; m_tag[side][idx] = tag;
        m_msk[side][idx] = msk; m_rbn[side][idx] = rbn; m_pr[side][idx] = pr;
        #1 cfg_we = 1'b0;
    endtask

    function automatic logic [31:0] pick_mask(int k);
        case (k)
            0: return 32'hF000_0000;
            1: return 32'hFF00_0000;
            2: return 32'hFFFE_0000;
            default: return 32'hFFFF_F000;
        endcase
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    initial begin
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < N; i++) begin
                m_sv[s][i] = 0; m_uv[s][i] = 0; m_tag[s][i] = '0;
                m_msk[s][i] = '0; m_rbn[s][i] = '0; m_pr[s][i] = '0;
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        lbl = "R1";
        step(32'h0000_0000, 0, 0, 0);
        step(32'hFFFF_FFFF, 1, 1, 1);
        step(32'h1234_5678, 1, 0, 0);

        lbl = "R13";
        load(0, 0, 1, 0, 32'h1000_0000, 32'hF000_0000, 32'h8000_0000, 2'd2);
        step(32'h1234_5678, 0, 0, 0);   // expect raddr 8234_5678 (R5)
        lbl = "R4";
        step(32'h1FFF_FFFF, 0, 0, 1);
        step(32'h2000_0000, 0, 0, 0);
        lbl = "R3";
        step(32'h1234_5678, 0, 1, 0);   // user, not enabled
        lbl = "R2";
        step(32'h1234_5678, 1, 0, 0);   // data bank empty
        lbl = "R5";
        load(1, 3, 1, 1, 32'h4000_0000, 32'hFFFE_0000, 32'h0AA0_0000, 2'd1);
        step(32'h4001_ABCD, 1, 1, 0);
        lbl = "R9";
        step(32'h4001_ABCD, 1, 1, 1);   // write to read-only: fault (R12)
        lbl = "R8";
        load(1, 0, 1, 1, 32'h4000_0000, 32'hF000_0000, 32'h7000_0000, 2'd0);
        step(32'h4001_0000, 1, 0, 0);   // skip idx0, take idx3
        step(32'h4F00_0000, 1, 0, 0);   // only idx0 matches: fault
        lbl = "R10";
        load(1, 5, 1, 1, 32'h4000_0000, 32'hFF00_0000, 32'h5500_0000, 2'd3);
        step(32'h4001_0000, 1, 0, 0);   // idx3 beats idx5
        lbl = "R6";
        step(32'h4001_0000, 1, 0, 1);   // write skips idx3, idx5 grants rw
        step(32'h40F0_0000, 1, 1, 1);
        lbl = "R7";
        step(32'h1000_0004, 0, 0, 0);
        lbl = "R11";
        step(32'h9000_0000, 1, 0, 1);
        lbl = "R12";
        load(0, 7, 0, 1, 32'hC000_0000, 32'hC000_0000, 32'h0, 2'd0);
        step(32'hC123_4567, 0, 1, 0);
        step(32'hC123_4567, 0, 0, 0);

        lbl = "R10";
        for (int n = 0; n < 600; n++) begin
            if (n % 4 == 0) begin
                logic [31:0] mk = pick_mask(int'($urandom_range(0, 3)));
                load(1'($urandom_range(0, 1)), int'($urandom_range(0, N - 1)),
                     1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                     $urandom & mk, mk, $urandom & mk, 2'($urandom_range(0, 3)));
            end else begin
                int s = int'($urandom_range(0, 1));
                int k = int'($urandom_range(0, N - 1));
                logic [31:0] ea;
                if ($urandom_range(0, 3) != 0) ea = m_tag[s][k] | ($urandom & ~m_msk[s][k]);
                else ea = $urandom;
                step(ea, s[0], 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            end
        end

        finish_run();
    end
endmodule